// File: doc/BRIEF.md
# Dead-Zone Flash Converter Decoder

This block is the digital back end of a flash analog-to-digital converter whose comparators behave ambipolarly. Comparators whose thresholds sit well above or well below the sampled input both switch on, and only those within a window around the input stay off. The comparator bank is hysteretic, so every conversion begins by forcing all comparators to a common state. The block drives that clear phase, waits for the bank to settle, samples the 63-bit comparator word and turns the run of zeros in it into a 6-bit code.

The code is taken from one edge of the zero run: the upper edge in max mode, the lower edge in min mode. A word with no zero, or with more than one separate run of zeros, cannot be trusted. Such a word raises an error flag and leaves the last good code in place. Conversions follow one another back to back. Each one ends with a one-cycle valid strobe, so one code is produced per sample period. Both phase lengths come from inputs, so the sample period can be matched to the settling time of the analog bank.

Top module: `dzone_flash_decoder`

## Requirements
- R1: While `rst_n` is low, `cmp_clr` is 1 and `code`, `code_vld` and `code_err` are 0.
- R2: Each conversion starts with `cmp_clr` high for exactly `clr_len`+1 cycles. The first conversion starts in the cycle in which reset is released.
- R3: After `cmp_clr` falls, `code_vld` rises exactly `settle_len`+3 cycles later. The conversion period is therefore `clr_len`+`settle_len`+4 cycles. Values on `cmp_word` and `sel_max` while `cmp_clr` is high have no effect on the result.
- R4: When `sel_max`=1 at capture and the word holds exactly one run of zeros, `code` is the index of the highest zero bit. Bit 0 of `cmp_word` is the lowest threshold.
- R5: When `sel_max`=0 at capture and the word holds exactly one run of zeros, `code` is the index of the lowest zero bit.
- R6: A word with no zero bit (all ones) gives `code_err`=1 with the valid strobe and leaves `code` unchanged.
- R7: A word with two or more zero runs separated by ones gives `code_err`=1 and leaves `code` unchanged.
- R8: `code_err` is updated on every valid strobe and returns to 0 on the next good conversion.
- R9: `code_vld` lasts one cycle and coincides with the first clear cycle of the next conversion. `cmp_clr` is never high in a capture cycle, so the captured word does not change while `cmp_clr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_word | input | 63 | Comparator outputs, bit 0 = lowest threshold |
| sel_max | input | 1 | 1: code from the upper edge of the zero run; 0: from the lower edge |
| clr_len | input | 4 | Clear phase length minus one, in cycles |
| settle_len | input | 4 | Settle phase length minus one, in cycles |
| cmp_clr | output | 1 | Clear command to the comparator bank |
| code | output | 6 | Converted code |
| code_vld | output | 1 | One-cycle strobe marking a finished conversion |
| code_err | output | 1 | Last conversion saw no zero run or more than one |

## Verification
The hardest case to reach from the ports is a change on `cmp_word` that must not matter: noise during the clear phase, together with a change of edge mode, is followed by a clean word in time for capture. The bench therefore drives random values on `cmp_word` and an inverted `sel_max` on every clear phase, and applies the real pattern only after `cmp_clr` falls. The error-hold path relies on a good code being in place first. Directed all-ones and split-run words are therefore placed right after known good codes, and random error words are mixed into the random run so that the held value keeps changing.

// File: rtl/dzfd_pkg.sv
package dzfd_pkg;

  typedef enum logic [1:0] {
    ST_CLR    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CAP    = 2'd2,
    ST_DONE   = 2'd3
  } conv_st_t;

endpackage

// File: rtl/dzfd_seq.sv
module dzfd_seq
  import dzfd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] clr_len,
  input  logic [CNT_W-1:0] settle_len,
  output logic             clr_on,
  output logic             cap_en,
  output logic             dec_en
);

  conv_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + CNT_W'(1);
    unique case (st_q)
      ST_CLR: begin
        if (cnt_q == clr_len) begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == settle_len) begin
          st_d  = ST_CAP;
          cnt_d = '0;
        end
      end
      ST_CAP: begin
        st_d  = ST_DONE;
        cnt_d = '0;
      end
      ST_DONE: begin
        st_d  = ST_CLR;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_CLR;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CLR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign clr_on = (st_q == ST_CLR);
  assign cap_en = (st_q == ST_CAP);
  assign dec_en = (st_q == ST_DONE);

endmodule

// File: rtl/dzfd_capture.sv
module dzfd_capture #(
  parameter int W = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] word_in,
  input  logic         mode_in,
  output logic [W-1:0] word_q,
  output logic         mode_q
);

  logic [W-1:0] word_d;
  logic         mode_d;

  always_comb begin
    word_d = word_q;
    mode_d = mode_q;
    if (cap_en) begin
      word_d = word_in;
      mode_d = mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '1;
      mode_q <= 1'b0;
    end else begin
      word_q <= word_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/dzfd_run_finder.sv
module dzfd_run_finder #(
  parameter int W      = 63,
  parameter int CODE_W = 6
) (
  input  logic [W-1:0]      vec,
  output logic [CODE_W-1:0] lo_idx,
  output logic [CODE_W-1:0] hi_idx,
  output logic              bad
);

  localparam int RUN_W = $clog2(W + 1);

  logic [W-1:0]     run_start;
  logic [RUN_W-1:0] n_runs;

  // A zero run starts where a zero has a one (or the bottom edge) below it.
  generate
    for (genvar g = 0; g < W; g++) begin : g_start
      if (g == 0) begin : g_bottom
        assign run_start[g] = ~vec[g];
      end else begin : g_upper
        assign run_start[g] = ~vec[g] & vec[g-1];
      end
    end
  endgenerate

  always_comb begin
    n_runs = '0;
    for (int i = 0; i < W; i++) begin
      n_runs = n_runs + RUN_W'(run_start[i]);
    end
  end

  always_comb begin
    lo_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!vec[i]) lo_idx = CODE_W'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (!vec[i]) hi_idx = CODE_W'(i);
    end
  end

  assign bad = (n_runs != RUN_W'(1));

endmodule

// File: rtl/dzfd_result.sv
module dzfd_result #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic              use_hi,
  input  logic [CODE_W-1:0] lo_idx,
  input  logic [CODE_W-1:0] hi_idx,
  input  logic              bad,
  output logic [CODE_W-1:0] code_q,
  output logic              vld_q,
  output logic              err_q
);

  logic [CODE_W-1:0] code_d;
  logic              err_d;

  always_comb begin
    code_d = code_q;
    err_d  = err_q;
    if (dec_en) begin
      err_d = bad;
      if (!bad) code_d = use_hi ? hi_idx : lo_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      err_q  <= err_d;
      vld_q  <= dec_en;
    end
  end

endmodule

// File: rtl/dzone_flash_decoder.sv
module dzone_flash_decoder #(
  parameter int  CODE_W = 6,
  parameter int  CNT_W  = 4,
  localparam int W      = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cmp_word,
  input  logic              sel_max,
  input  logic [CNT_W-1:0]  clr_len,
  input  logic [CNT_W-1:0]  settle_len,
  output logic              cmp_clr,
  output logic [CODE_W-1:0] code,
  output logic              code_vld,
  output logic              code_err
);

  logic              cap_en;
  logic              dec_en;
  logic [W-1:0]      samp_q;
  logic              mode_q;
  logic [CODE_W-1:0] lo_idx;
  logic [CODE_W-1:0] hi_idx;
  logic              bad;

  dzfd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_len    (clr_len),
    .settle_len (settle_len),
    .clr_on     (cmp_clr),
    .cap_en     (cap_en),
    .dec_en     (dec_en)
  );

  dzfd_capture #(.W(W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .word_in (cmp_word),
    .mode_in (sel_max),
    .word_q  (samp_q),
    .mode_q  (mode_q)
  );

  dzfd_run_finder #(.W(W), .CODE_W(CODE_W)) u_find (
    .vec    (samp_q),
    .lo_idx (lo_idx),
    .hi_idx (hi_idx),
    .bad    (bad)
  );

  dzfd_result #(.CODE_W(CODE_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec_en (dec_en),
    .use_hi (mode_q),
    .lo_idx (lo_idx),
    .hi_idx (hi_idx),
    .bad    (bad),
    .code_q (code),
    .vld_q  (code_vld),
    .err_q  (code_err)
  );

endmodule

// File: rtl/dzfd_checker.sv
module dzfd_checker #(
  parameter int W      = 63,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_clr,
  input logic              code_vld,
  input logic              code_err,
  input logic [CODE_W-1:0] code,
  input logic [W-1:0]      samp_q
);

  // R9: the strobe is a single cycle
  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> !code_vld);

  // R9: the strobe arrives with the first clear cycle of the next conversion
  assert_vld_on_clr_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> $rose(cmp_clr));

  // R9: no capture happens while the bank is being cleared
  assert_no_cap_in_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clr && $past(cmp_clr)) |-> $stable(samp_q));

  // R6, R7: an error strobe leaves the code where it was
  assert_hold_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && code_err) |-> (code == $past(code)));

  // R4, R5: a good code always points at a zero of the captured word
  assert_code_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && !code_err) |-> (samp_q[code] == 1'b0));

  // R3: the code moves only together with a strobe
  assert_code_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |-> $stable(code));

endmodule

bind dzone_flash_decoder dzfd_checker #(.W(W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmp_clr  (cmp_clr),
  .code_vld (code_vld),
  .code_err (code_err),
  .code     (code),
  .samp_q   (samp_q)
);

// File: tb/sim_dzone_flash_decoder.sv
module sim_dzone_flash_decoder;

  localparam int CLK_P = 10;
  localparam int W     = 63;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cmp_word;
  logic         sel_max;
  logic [3:0]   clr_len;
  logic [3:0]   settle_len;
  logic         cmp_clr;
  logic [5:0]   code;
  logic         code_vld;
  logic         code_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  logic [5:0] exp_code = '0;
  logic       exp_err;

  dzone_flash_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_word   (cmp_word),
    .sel_max    (sel_max),
    .clr_len    (clr_len),
    .settle_len (settle_len),
    .cmp_clr    (cmp_clr),
    .code       (code),
    .code_vld   (code_vld),
    .code_err   (code_err)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] win(input int lo, input int hi);
    logic [W-1:0] w = '1;
    for (int i = lo; i <= hi; i++) w[i] = 1'b0;
    return w;
  endfunction

  function automatic logic [W-1:0] junk();
    return {$urandom(), $urandom()};
  endfunction

  // Reference model: count zero runs and locate edges by a linear scan.
  task automatic model(input logic [W-1:0] w, input logic m);
    int  runs = 0;
    int  lo   = -1;
    int  hi   = -1;
    bit  prev_one = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (!w[i]) begin
        if (prev_one) runs++;
        if (lo < 0) lo = i;
        hi = i;
        prev_one = 1'b0;
      end else begin
        prev_one = 1'b1;
      end
    end
    exp_err = (runs != 1);
    if (!exp_err) exp_code = m ? 6'(hi) : 6'(lo);
  endtask

  // Entered at a negedge inside the first clear cycle of a conversion.
  task automatic convert(input logic [W-1:0] w, input logic m, input string req);
    int clr_cnt = 0;
    int low_cnt = 0;
    while (cmp_clr) begin
      cmp_word = junk();
      sel_max  = ~m;
      clr_cnt++;
      @(negedge clk);
      if (clr_cnt > 20) break;
    end
    cmp_word = w;
    sel_max  = m;
    while (!code_vld) begin
      low_cnt++;
      @(negedge clk);
      if (low_cnt > 40) break;
    end
    model(w, m);
    chk(clr_cnt == int'(clr_len) + 1, "R2 clear length", clr_cnt, int'(clr_len) + 1);
    chk(low_cnt == int'(settle_len) + 3, "R3 clear-fall to strobe", low_cnt, int'(settle_len) + 3);
    chk(cmp_clr == 1'b1, "R9 strobe with clear", cmp_clr, 1);
    chk(code_err == exp_err, {req, " error flag"}, code_err, exp_err);
    chk(code == exp_code, {req, " code"}, code, exp_code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n      = 1'b0;
    cmp_word   = '1;
    sel_max    = 1'b0;
    clr_len    = 4'd2;
    settle_len = 4'd3;
    repeat (3) @(negedge clk);
    chk(cmp_clr == 1'b1, "R1 clear in reset", cmp_clr, 1);
    chk(code == 6'd0, "R1 code in reset", code, 0);
    chk(code_vld == 1'b0, "R1 strobe in reset", code_vld, 0);
    chk(code_err == 1'b0, "R1 error in reset", code_err, 0);
    rst_n = 1'b1;

    // Directed edge cases
    convert(win(0, 0), 1'b1, "R4 single zero at bottom");
    convert(win(62, 62), 1'b0, "R5 single zero at top");
    convert(win(10, 20), 1'b1, "R4 window upper edge");
    convert(win(10, 20), 1'b0, "R5 window lower edge");
    convert('1, 1'b1, "R6 all ones");
    convert(win(30, 33) & win(40, 41), 1'b0, "R7 split runs");
    convert(win(5, 9), 1'b1, "R8 error cleared");
    convert('0, 1'b1, "R4 all zeros");
    convert('0, 1'b0, "R5 all zeros");

    // Shortest phases, then longest
    clr_len = 4'd0; settle_len = 4'd0;
    convert(win(3, 50), 1'b1, "R3 short phases");
    clr_len = 4'd15; settle_len = 4'd15;
    convert(win(3, 50), 1'b0, "R3 long phases");
    clr_len = 4'd1; settle_len = 4'd2;

    // Random mix of good and bad words
    for (int k = 0; k < 120; k++) begin
      int a = int'($urandom_range(62, 0));
      int b = int'($urandom_range(62, 0));
      int lo = (a < b) ? a : b;
      int hi = (a < b) ? b : a;
      int kind = int'($urandom_range(9, 0));
      logic [W-1:0] w;
      logic m = 1'(($urandom() & 1));
      if (kind == 0) w = '1;
      else if (kind == 1 && hi - lo >= 2) w = win(lo, hi) | (63'(1) << (lo + 1));
      else w = win(lo, hi);
      if (k % 30 == 29) begin
        clr_len    = 4'($urandom_range(15, 0));
        settle_len = 4'($urandom_range(15, 0));
      end
      convert(w, m, (kind <= 1) ? "R7 random word" : (m ? "R4 random word" : "R5 random word"));
    end

    @(negedge clk);
    chk(code_vld == 1'b0, "R9 strobe one cycle", code_vld, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule